// File: doc/BRIEF.md
# Walsh-Spread Serial Address Encoder

This block spreads a node's destination address with the node's own Walsh code. It shifts the result out one chip per clock onto a one-bit code line. Several nodes in a row share that line, and each uses a different orthogonal code. A receiver can therefore separate the overlapping addresses later. All nodes in the row run on one clock and start together on a common sync pulse. Each node starts only if it has a request pending.

After a start, the block latches the address and sends every address bit, most significant first. Each address bit is XORed with all chips of the code word, taken from the most significant chip down. Each address bit therefore fills one code length of clocks, and the four-bit default transfer lasts 32 clocks. In the clock after the final chip, a one-cycle end pulse tells downstream logic that the coded address is on its way. Whenever no transfer is running, the chip output stays at 0 so that it adds nothing to the shared line.

The code word is a parameter of each instance. A typical row of four nodes uses the codes 01010101, 00110011, 01100110 and 00001111.

Top module: `walsh_addr_spreader`

## Requirements
- R1: After reset, chip_o, busy_o and sync_o are all 0.
- R2: A transfer starts at the clock edge where req_i and sync_i are both 1 while busy_o is 0. With only one of them high, busy_o stays 0.
- R3: In transfer cycle k (k = 0 to 31, cycle 0 being the first cycle after the start edge), chip_o equals address bit (3 - k/8) XOR code bit (7 - k%8). Both indices count bit 0 as the least significant bit.
- R4: busy_o is 1 for exactly ADDR_W*CODE_LEN consecutive cycles, which is 32 by default.
- R5: sync_o is 1 for exactly one cycle: the cycle right after the last chip, when busy_o has already returned to 0.
- R6: chip_o is 0 in every cycle where busy_o is 0.
- R7: The address is captured at the start edge. Changes on addr_i during a transfer leave the chip stream unchanged.
- R8: A sync_i pulse while busy_o is 1 is ignored. The chip stream and the end time of the running transfer are unchanged.
- R9: The code word is set per instance by the CODE parameter. An instance built with 00001111 sends the same address spread by that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the row |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Node has an address to send |
| sync_i | input | 1 | Row-wide start pulse |
| addr_i | input | ADDR_W | Destination address to spread |
| chip_o | output | 1 | Spread chip for the code line, 0 when idle |
| busy_o | output | 1 | Transfer in progress |
| sync_o | output | 1 | One-cycle end-of-coding pulse |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a running transfer. A faulty design could silently restart, or reload its counters, and still produce chips that look plausible. The bench holds req_i high and fires sync_i again at chip 10. It checks that all 32 chips, and the end pulse, fall exactly where an undisturbed transfer would put them. A similar run inverts addr_i after the start to show the latched address is used. A second instance with a different code checks that the spreading follows the parameter.

// File: rtl/walsh_addr_spreader.sv
module walsh_addr_spreader #(
  parameter int ADDR_W = 4,
  parameter int CODE_LEN = 8,
  parameter logic [CODE_LEN-1:0] CODE = 8'b01010101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              sync_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              chip_o,
  output logic              busy_o,
  output logic              sync_o
);
  localparam int CW = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;
  localparam int AW = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  logic [CW-1:0]       chip_q;
  logic [AW-1:0]       bit_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [CODE_LEN-1:0] code_q;
  logic                busy_q;
  logic                sync_q;

  wire start     = req_i & sync_i & ~busy_q;
  wire last_chip = (chip_q == CW'(CODE_LEN - 1));
  wire last_bit  = (bit_q == AW'(ADDR_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip_q <= '0;
      bit_q  <= '0;
      addr_q <= '0;
      code_q <= CODE;
      busy_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= busy_q & last_chip & last_bit;
      if (start) begin
        busy_q <= 1'b1;
        chip_q <= '0;
        bit_q  <= '0;
        addr_q <= addr_i;
        code_q <= CODE;
      end else if (busy_q) begin
        code_q <= {code_q[CODE_LEN-2:0], code_q[CODE_LEN-1]};
        if (last_chip) begin
          chip_q <= '0;
          addr_q <= addr_q << 1;
          if (last_bit) begin
            busy_q <= 1'b0;
            bit_q  <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end else begin
          chip_q <= chip_q + 1'b1;
        end
      end
    end
  end

  assign chip_o = busy_q & (addr_q[ADDR_W-1] ^ code_q[CODE_LEN-1]);
  assign busy_o = busy_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/walsh_addr_spreader_chk.sv
module walsh_addr_spreader_chk #(
  parameter int ADDR_W = 4,
  parameter int CODE_LEN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic sync_i,
  input logic chip_o,
  input logic busy_o,
  input logic sync_o
);
  localparam int TOTAL = ADDR_W * CODE_LEN;
  localparam int TW = $clog2(TOTAL + 1) + 1;

  logic [TW-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else run_cnt <= '0;
  end

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !chip_o);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i && sync_i) |=> busy_o);
  p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !(req_i && sync_i)) |=> !busy_o);
  p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);
  p_pulse_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> sync_o);
  p_run_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_cnt == TW'(TOTAL)));
  p_busy_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_cnt < TW'(TOTAL)));
endmodule

bind walsh_addr_spreader walsh_addr_spreader_chk #(.ADDR_W(ADDR_W), .CODE_LEN(CODE_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .sync_i(sync_i),
  .chip_o(chip_o), .busy_o(busy_o), .sync_o(sync_o));

// File: tb/walsh_addr_spreader_tb_top.sv
module walsh_addr_spreader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic sync = 1'b0;
  logic [3:0] addr = 4'h0;
  logic chip_a, busy_a, sync_a, chip_b, busy_b, sync_b;
  int checks = 0;
  int errors = 0;

  localparam logic [7:0] CODE_A = 8'b01010101;
  localparam logic [7:0] CODE_B = 8'b00001111;

  always #4 clk = ~clk;

  walsh_addr_spreader #(.ADDR_W(4), .CODE_LEN(8), .CODE(CODE_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .sync_i(sync), .addr_i(addr),
    .chip_o(chip_a), .busy_o(busy_a), .sync_o(sync_a));

  walsh_addr_spreader #(.ADDR_W(4), .CODE_LEN(8), .CODE(CODE_B)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .sync_i(sync), .addr_i(addr),
    .chip_o(chip_b), .busy_o(busy_b), .sync_o(sync_b));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_chip(input logic [7:0] code, input logic [3:0] a, input int k);
    return a[3 - k / 8] ^ code[7 - k % 8];
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(chip_a == 1'b0, "R1 chip after reset", chip_a, 0);
    chk(busy_a == 1'b0, "R1 busy after reset", busy_a, 0);
    chk(sync_a == 1'b0, "R1 sync after reset", sync_a, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_half_start();
    addr = 4'hF;
    req = 1'b1; sync = 1'b0;
    @(negedge clk);
    chk(busy_a == 1'b0, "R2 req without sync", busy_a, 0);
    chk(chip_a == 1'b0, "R6 idle chip with req", chip_a, 0);
    req = 1'b0; sync = 1'b1;
    @(negedge clk);
    chk(busy_a == 1'b0, "R2 sync without req", busy_a, 0);
    chk(chip_a == 1'b0, "R6 idle chip with sync", chip_a, 0);
    sync = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_xfer(input logic [3:0] a, input bit wobble_addr, input bit extra_sync,
                        input string tag);
    addr = a; req = 1'b1; sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    for (int k = 0; k < 32; k++) begin
      chk(busy_a == 1'b1, {tag, " R4 busy during transfer"}, busy_a, 1);
      chk(chip_a == exp_chip(CODE_A, a, k), {tag, " R3 chip value"}, chip_a, exp_chip(CODE_A, a, k));
      chk(chip_b == exp_chip(CODE_B, a, k), {tag, " R9 chip value other code"}, chip_b, exp_chip(CODE_B, a, k));
      chk(sync_a == 1'b0, {tag, " R5 no early end pulse"}, sync_a, 0);
      if (wobble_addr) addr = ~a ^ 4'(k);
      sync = (extra_sync && (k == 10 || k == 20));
      @(negedge clk);
    end
    sync = 1'b0;
    chk(busy_a == 1'b0, {tag, " R4 busy drops after 32"}, busy_a, 0);
    chk(sync_a == 1'b1, {tag, " R5 end pulse"}, sync_a, 1);
    chk(sync_b == 1'b1, {tag, " R9 end pulse other code"}, sync_b, 1);
    chk(chip_a == 1'b0, {tag, " R6 chip zero after end"}, chip_a, 0);
    req = 1'b0;
    @(negedge clk);
    chk(sync_a == 1'b0, {tag, " R5 pulse one cycle"}, sync_a, 0);
    chk(busy_a == 1'b0, {tag, " R8 no restart"}, busy_a, 0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_half_start();
    t_xfer(4'b1010, 1'b0, 1'b0, "plain");
    t_xfer(4'b0000, 1'b0, 1'b0, "zeros");
    t_xfer(4'b1111, 1'b0, 1'b0, "ones");
    t_xfer(4'b0110, 1'b1, 1'b0, "R7 addr change");
    t_xfer(4'b1001, 1'b0, 1'b1, "R8 sync while busy");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule